// File: doc/BRIEF.md
# Multi-Register Transfer Sequencer

This block walks an eight-entry file of extended-precision registers and moves the chosen ones to or from a word-addressed memory port. Each selected register is moved as three 32-bit words. The block stops after the last selected register, or at the first fault. A 16-bit extension word sets the move. It gives the direction, where the register list comes from, and how list bits map onto registers. A separate mode flag says whether the effective address is pre-decremented. In pre-decrement mode the walk runs from register 7 down to register 0. In every other mode it runs from register 0 up to register 7.

When the list is dynamic, the block puts the index of a data register (extension bits 6:4) on `dreg_idx_o`, and the surrounding logic returns that register's value on `dreg_val_i`. The block captures everything it needs in the start cycle. It then issues one word request at a time. Each request is held until the memory side answers with `xfer_done_i` or `xfer_fault_i`. At the end, `done_o` pulses for one cycle. With it come `err_o` and the address to write back to the address register, on `final_addr_o`.

The controller has three states:
- `ST_IDLE` waits for a start.
- `ST_MOVE` presents word requests.
- `ST_FINISH` produces the completion pulse.

Its transitions are:
- **launch**: `ST_IDLE` to `ST_MOVE` on a start with a non-empty list.
- **skip**: `ST_IDLE` to `ST_FINISH` on a start with an empty list.
- **step**: `ST_MOVE` to `ST_MOVE` when a word is accepted and work remains.
- **drain**: `ST_MOVE` to `ST_FINISH` when the last word of the last register is accepted.
- **abort**: `ST_MOVE` to `ST_FINISH` on a fault.
- **retire**: `ST_FINISH` to `ST_IDLE`, always.

Top module: `mreg_xfer_seq`

## Requirements
- R1: Extension bit 13 set means registers are written to memory (`xfer_wr_o`=1). Bit 13 clear means memory is read into registers (`xfer_wr_o`=0). The value is held for the whole sequence.
- R2: With extension bit 11 set, the 8-bit mask is `dreg_val_i[7:0]` of the data register whose index (extension bits 6:4) is shown on `dreg_idx_o`, and the extension low byte is ignored. With bit 11 clear, the mask is extension bits 7:0.
- R3: With `predec_i`=1, selected registers are visited in descending index order. Otherwise they are visited in ascending order.
- R4: With extension bit 12 set, register n is selected by mask bit 7-n. With it clear, register n is selected by mask bit n.
- R5: Each selected register produces three requests with `xfer_word_o` = 0, 1, 2 at addresses rising by 4. Each request holds its register, word and address until `xfer_done_i` or `xfer_fault_i`.
- R6: In pre-decrement mode a register's first word address is 12 below the previous register's, starting from `base_addr_i`-12. In other modes it is 12 above, starting at `base_addr_i`. At completion `final_addr_o` is the lowest register base used (pre-decrement) or `base_addr_i` + 12 x count (other modes).
- R7: Unselected registers take no cycles. An empty mask raises `done_o` in the cycle right after the start edge, with no requests and `final_addr_o` = `base_addr_i`.
- R8: A fault ends the sequence. No further request is issued, `done_o` pulses with `err_o`=1, and `final_addr_o` is the base address of the register that faulted.
- R9: A start pulse while `busy_o` is high has no effect on the running sequence or on its result.
- R10: `done_o` is high for exactly one cycle per sequence, with `err_o`=0 on a fault-free run. With zero-wait responses it arrives 3N+1 cycles after the start edge, where N is the number of selected registers.
- R11: After reset the block is idle, with `busy_o`, `xfer_req_o` and `done_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, sampled in `ST_IDLE` only |
| ext_word_i | input | 16 | Extension word: direction, list source, list mapping, data register index, static mask |
| predec_i | input | 1 | Effective address is pre-decrement |
| base_addr_i | input | 32 | Address register value at start |
| dreg_val_i | input | 32 | Value of the data register selected by `dreg_idx_o` |
| dreg_idx_o | output | 3 | Index of the data register that supplies a dynamic list |
| xfer_req_o | output | 1 | Word transfer request |
| xfer_wr_o | output | 1 | 1 = register to memory, 0 = memory to register |
| xfer_reg_o | output | 3 | Register being moved |
| xfer_word_o | output | 2 | Word index within the register (0..2) |
| xfer_addr_o | output | 32 | Byte address of the word |
| xfer_done_i | input | 1 | Current word completed |
| xfer_fault_i | input | 1 | Current word faulted |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Sequence aborted by a fault, valid with `done_o` |
| final_addr_o | output | 32 | Address for write-back, valid with `done_o` |

## Verification
A request appears in the cycle after the start edge. Each word advances on the edge that samples a response, so with L wait cycles per word, `done_o` rises (L+1) x W + 1 cycles after the start edge, where W is the number of words answered, including a faulting one. An empty list gives W = 0. The bench drives inputs on falling edges and has its responder answer on falling edges. It counts rising edges, and records the completion pulse together with its cycle number. It then compares that cycle number with the formula above, and compares every logged request with a model built from the extension word. It waits several idle cycles after each completion to confirm that no second pulse and no late request appear.

// File: rtl/xfer_seq_pkg.sv
package xfer_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_MOVE   = 2'd1,
        ST_FINISH = 2'd2
    } seq_state_e;

endpackage

// File: rtl/xfer_mask_map.sv
// Maps raw list bits onto register select lines, mirrored or straight.
module xfer_mask_map #(
    parameter int N = 8
) (
    input  logic [N-1:0] raw_mask,
    input  logic         mirror,
    output logic [N-1:0] reg_sel
);
    for (genvar n = 0; n < N; n++) begin : g_bit
        assign reg_sel[n] = mirror ? raw_mask[N-1-n] : raw_mask[n];
    end
endmodule

// File: rtl/xfer_reg_picker.sv
// Picks the next pending register: highest index when descending, else lowest.
module xfer_reg_picker #(
    parameter  int N  = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  pending,
    input  logic          descend,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |pending;
        idx = '0;
        if (descend) begin
            for (int i = 0; i < N; i++) begin
                if (pending[i]) idx = IW'(i);
            end
        end else begin
            for (int i = N - 1; i >= 0; i--) begin
                if (pending[i]) idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/xfer_addr_step.sv
// Word address inside a register slot and the pointer one slot away.
module xfer_addr_step #(
    parameter int AW  = 32,
    parameter int BPW = 4,
    parameter int WPR = 3,
    parameter int WIW = 2
) (
    input  logic [AW-1:0]  ptr,
    input  logic [WIW-1:0] widx,
    output logic [AW-1:0]  word_addr,
    output logic [AW-1:0]  ptr_down,
    output logic [AW-1:0]  ptr_up
);
    localparam logic [AW-1:0] SLOT = AW'(BPW * WPR);
    localparam logic [AW-1:0] WSTP = AW'(BPW);

    assign word_addr = ptr + (AW'(widx) * WSTP);
    assign ptr_down  = ptr - SLOT;
    assign ptr_up    = ptr + SLOT;
endmodule

// File: rtl/mreg_xfer_seq.sv
module mreg_xfer_seq
    import xfer_seq_pkg::*;
#(
    parameter  int NUM_REGS      = 8,
    parameter  int WORDS_PER_REG = 3,
    parameter  int ADDR_W        = 32,
    parameter  int DATA_W        = 32,
    localparam int RIW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int WIW = (WORDS_PER_REG > 1) ? $clog2(WORDS_PER_REG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [15:0]       ext_word_i,
    input  logic              predec_i,
    input  logic [ADDR_W-1:0] base_addr_i,
    input  logic [DATA_W-1:0] dreg_val_i,
    output logic [2:0]        dreg_idx_o,
    output logic              xfer_req_o,
    output logic              xfer_wr_o,
    output logic [RIW-1:0]    xfer_reg_o,
    output logic [WIW-1:0]    xfer_word_o,
    output logic [ADDR_W-1:0] xfer_addr_o,
    input  logic              xfer_done_i,
    input  logic              xfer_fault_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [ADDR_W-1:0] final_addr_o
);
    localparam int BPW       = DATA_W / 8;
    localparam int SLOT      = BPW * WORDS_PER_REG;
    localparam int B_DIR     = 13;
    localparam int B_MIRROR  = 12;
    localparam int B_DYN     = 11;
    localparam logic [WIW-1:0] LAST_W = WIW'(WORDS_PER_REG - 1);

    seq_state_e state_q, state_d;

    logic [NUM_REGS-1:0] pending_q;
    logic [WIW-1:0]      widx_q;
    logic [ADDR_W-1:0]   ptr_q;
    logic                dir_q;
    logic                desc_q;
    logic                err_q;

    logic [NUM_REGS-1:0] raw_mask;
    logic [NUM_REGS-1:0] sel_map;
    logic                pick_any;
    logic [RIW-1:0]      cur_reg;
    logic [ADDR_W-1:0]   word_addr, ptr_down, ptr_up;
    logic                more_after;
    logic                word_ok, word_bad, reg_end;

    // list source and bit mapping
    assign dreg_idx_o = ext_word_i[6:4];
    assign raw_mask   = ext_word_i[B_DYN] ? dreg_val_i[NUM_REGS-1:0]
                                          : ext_word_i[NUM_REGS-1:0];

    xfer_mask_map #(.N(NUM_REGS)) u_map (
        .raw_mask (raw_mask),
        .mirror   (ext_word_i[B_MIRROR]),
        .reg_sel  (sel_map)
    );

    xfer_reg_picker #(.N(NUM_REGS)) u_pick (
        .pending  (pending_q),
        .descend  (desc_q),
        .any      (pick_any),
        .idx      (cur_reg)
    );

    xfer_addr_step #(
        .AW  (ADDR_W),
        .BPW (BPW),
        .WPR (WORDS_PER_REG),
        .WIW (WIW)
    ) u_addr (
        .ptr       (ptr_q),
        .widx      (widx_q),
        .word_addr (word_addr),
        .ptr_down  (ptr_down),
        .ptr_up    (ptr_up)
    );

    assign more_after = |(pending_q & ~(NUM_REGS'(1) << cur_reg));
    assign word_bad   = (state_q == ST_MOVE) && xfer_fault_i;
    assign word_ok    = (state_q == ST_MOVE) && xfer_done_i && !xfer_fault_i;
    assign reg_end    = word_ok && (widx_q == LAST_W);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = (|sel_map) ? ST_MOVE : ST_FINISH;
            end
            ST_MOVE: begin
                if (word_bad)                    state_d = ST_FINISH;
                else if (reg_end && !more_after) state_d = ST_FINISH;
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // sequence datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending_q <= '0;
            widx_q    <= '0;
            ptr_q     <= '0;
            dir_q     <= 1'b0;
            desc_q    <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        pending_q <= sel_map;
                        widx_q    <= '0;
                        dir_q     <= ext_word_i[B_DIR];
                        desc_q    <= predec_i;
                        err_q     <= 1'b0;
                        ptr_q     <= (predec_i && |sel_map)
                                     ? base_addr_i - ADDR_W'(SLOT) : base_addr_i;
                    end
                end
                ST_MOVE: begin
                    if (word_bad) begin
                        err_q <= 1'b1;
                    end else if (word_ok) begin
                        if (widx_q == LAST_W) begin
                            widx_q             <= '0;
                            pending_q[cur_reg] <= 1'b0;
                            if (more_after)   ptr_q <= desc_q ? ptr_down : ptr_up;
                            else if (!desc_q) ptr_q <= ptr_up;
                        end else begin
                            widx_q <= widx_q + 1'b1;
                        end
                    end
                end
                ST_FINISH: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy_o       = (state_q != ST_IDLE);
        xfer_req_o   = (state_q == ST_MOVE);
        done_o       = (state_q == ST_FINISH);
        xfer_wr_o    = dir_q;
        xfer_reg_o   = cur_reg;
        xfer_word_o  = widx_q;
        xfer_addr_o  = word_addr;
        err_o        = err_q;
        final_addr_o = ptr_q;
    end

    // checks
    a_r11_move_has_work: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req_o |-> pick_any);

    a_r5_word_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req_o |-> (xfer_word_o <= LAST_W));

    a_r5_hold_until_answer: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req_o && !xfer_done_i && !xfer_fault_i) |=>
        (xfer_req_o && $stable(xfer_addr_o) && $stable(xfer_reg_o) && $stable(xfer_word_o)));

    a_r5_word_step: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req_o && xfer_done_i && !xfer_fault_i && xfer_word_o != LAST_W) |=>
        (xfer_req_o && xfer_addr_o == $past(xfer_addr_o) + ADDR_W'(BPW)
                    && xfer_reg_o == $past(xfer_reg_o)));

    a_r3_visit_order: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req_o && xfer_done_i && !xfer_fault_i && xfer_word_o == LAST_W) |=>
        (!xfer_req_o || (desc_q ? (xfer_reg_o < $past(xfer_reg_o))
                                : (xfer_reg_o > $past(xfer_reg_o)))));

    a_r1_dir_steady: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req_o |=> (!xfer_req_o || $stable(xfer_wr_o)));

    a_r8_fault_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req_o && xfer_fault_i) |=> (done_o && err_o && !xfer_req_o));

    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r9_start_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o && start_i) |=> busy_o);

    a_r10_done_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && xfer_req_o));

endmodule

// File: tb/sim_mreg_xfer_seq.sv
`timescale 1ns/1ps
module sim_mreg_xfer_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] ext_word_i = '0;
    logic        predec_i = 1'b0;
    logic [31:0] base_addr_i = '0;
    logic [31:0] dreg_val_i;
    logic [2:0]  dreg_idx_o;
    logic        xfer_req_o, xfer_wr_o;
    logic [2:0]  xfer_reg_o;
    logic [1:0]  xfer_word_o;
    logic [31:0] xfer_addr_o;
    logic        xfer_done_i = 1'b0;
    logic        xfer_fault_i = 1'b0;
    logic        busy_o, done_o, err_o;
    logic [31:0] final_addr_o;

    logic [31:0] dregs [8];
    assign dreg_val_i = dregs[dreg_idx_o];

    always #2 clk = ~clk;

    mreg_xfer_seq u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ext_word_i(ext_word_i),
        .predec_i(predec_i), .base_addr_i(base_addr_i), .dreg_val_i(dreg_val_i),
        .dreg_idx_o(dreg_idx_o), .xfer_req_o(xfer_req_o), .xfer_wr_o(xfer_wr_o),
        .xfer_reg_o(xfer_reg_o), .xfer_word_o(xfer_word_o), .xfer_addr_o(xfer_addr_o),
        .xfer_done_i(xfer_done_i), .xfer_fault_i(xfer_fault_i), .busy_o(busy_o),
        .done_o(done_o), .err_o(err_o), .final_addr_o(final_addr_o)
    );

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;

    // responder and completion log
    int lat = 0;
    int fault_at = -1;
    int waitc = 0;
    int nlog = 0;
    logic        log_wr   [64];
    logic [2:0]  log_reg  [64];
    logic [1:0]  log_word [64];
    logic [31:0] log_addr [64];
    int          ndone = 0;
    int          done_cyc = 0;
    logic        done_err;
    logic [31:0] done_addr;

    // expected model
    int          exp_n;
    logic        exp_wr   [64];
    logic [2:0]  exp_reg  [64];
    logic [1:0]  exp_word [64];
    logic [31:0] exp_addr [64];
    logic [31:0] exp_final;

    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        forever begin
            @(negedge clk);
            xfer_done_i  = 1'b0;
            xfer_fault_i = 1'b0;
            if (xfer_req_o) begin
                if (waitc < lat) begin
                    waitc++;
                end else begin
                    waitc = 0;
                    if (nlog < 64) begin
                        log_wr[nlog]   = xfer_wr_o;
                        log_reg[nlog]  = xfer_reg_o;
                        log_word[nlog] = xfer_word_o;
                        log_addr[nlog] = xfer_addr_o;
                    end
                    if (nlog == fault_at) xfer_fault_i = 1'b1;
                    else                  xfer_done_i  = 1'b1;
                    nlog++;
                end
            end
            if (done_o) begin
                ndone++;
                done_cyc  = cyc;
                done_err  = err_o;
                done_addr = final_addr_o;
            end
        end
    end

    task automatic chk(input string rq, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic build_expect(input logic [15:0] ext, input logic pd,
                                input logic [31:0] base, input int fat);
        logic [7:0]  m;
        logic [31:0] a;
        bit          stop;
        m = ext[11] ? dregs[ext[6:4]][7:0] : ext[7:0];
        a = base;
        exp_n = 0;
        stop = 0;
        for (int i = 0; i < 8 && !stop; i++) begin
            int  n;
            logic b;
            n = pd ? 7 - i : i;
            b = ext[12] ? m[7-n] : m[n];
            if (b) begin
                if (pd) a = a - 32'd12;
                for (int w = 0; w < 3 && !stop; w++) begin
                    exp_wr[exp_n]   = ext[13];
                    exp_reg[exp_n]  = 3'(n);
                    exp_word[exp_n] = 2'(w);
                    exp_addr[exp_n] = a + 32'(4 * w);
                    if (exp_n == fat) stop = 1;
                    exp_n++;
                end
                if (!pd && !stop) a = a + 32'd12;
            end
        end
        exp_final = a;
    endtask

    task automatic run_case(input string name, input string rq, input logic [15:0] ext,
                            input logic pd, input logic [31:0] base, input int l,
                            input int fat, input bit poke);
        int  c0;
        bit  seen;
        build_expect(ext, pd, base, fat);
        lat = l; fault_at = fat; waitc = 0; nlog = 0; ndone = 0;
        @(negedge clk);
        ext_word_i = ext; predec_i = pd; base_addr_i = base; start_i = 1'b1;
        c0 = cyc;
        @(negedge clk);
        start_i = 1'b0;
        if (poke) begin
            @(negedge clk);
            start_i = 1'b1; ext_word_i = 16'hFFFF; predec_i = ~pd; base_addr_i = 32'h5555_0000;
            @(negedge clk);
            start_i = 1'b0;
        end
        seen = 0;
        for (int k = 0; k < 3000 && !seen; k++) begin
            @(posedge clk); #1;
            if (ndone > 0) seen = 1;
        end
        chk("R10", {name, " done seen"}, 32'(seen), 32'd1);
        repeat (6) @(posedge clk);
        #1;
        chk("R10", {name, " single done pulse"}, 32'(ndone), 32'd1);
        chk(rq, {name, " request count"}, 32'(nlog), 32'(exp_n));
        for (int e = 0; e < exp_n && e < nlog; e++) begin
            chk("R1", {name, " direction"}, 32'(log_wr[e]), 32'(exp_wr[e]));
            chk(rq, {name, " register"}, 32'(log_reg[e]), 32'(exp_reg[e]));
            chk("R5", {name, " word index"}, 32'(log_word[e]), 32'(exp_word[e]));
            chk("R6", {name, " word address"}, log_addr[e], exp_addr[e]);
        end
        chk(fat >= 0 ? "R8" : "R10", {name, " error flag"}, 32'(done_err), 32'(fat >= 0));
        chk("R6", {name, " final address"}, done_addr, exp_final);
        chk("R10", {name, " done latency"}, 32'(done_cyc - c0), 32'((l + 1) * exp_n + 1));
        chk("R11", {name, " idle after"}, {29'd0, busy_o, xfer_req_o, done_o}, 32'd0);
    endtask

    initial begin
        #800000;
        nchk++; nfail++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) dregs[i] = 32'hDEAD_0000 | 32'(i);
        dregs[3] = 32'hFFFF_FF42;
        dregs[5] = 32'h0000_0100;
        repeat (4) @(negedge clk);
        chk("R11", "reset outputs", {29'd0, busy_o, xfer_req_o, done_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "idle after reset", {29'd0, busy_o, xfer_req_o, done_o}, 32'd0);

        // R1 R3 R6: static list, ascending, registers to memory
        run_case("asc_store", "R3", 16'h2005, 1'b0, 32'h0000_1000, 0, -1, 0);
        // R3 R6: pre-decrement, straight mapping, descending 7 then 0
        run_case("predec_store", "R3", 16'h2081, 1'b1, 32'h0000_2000, 0, -1, 0);
        // R4: mirrored mapping under pre-decrement, mask 03 selects 7 and 6
        run_case("predec_mirror", "R4", 16'h3003, 1'b1, 32'h0000_3000, 0, -1, 0);
        // R4 R1: mirrored mapping ascending, memory to registers
        run_case("post_mirror_load", "R4", 16'h1003, 1'b0, 32'h0000_4000, 0, -1, 0);
        // R2: dynamic list from data register 3 (low byte 42), waits of 1
        run_case("dynamic", "R2", 16'h2830, 1'b0, 32'h0000_5000, 1, -1, 0);
        // R7: empty static list
        run_case("empty_static", "R7", 16'h2000, 1'b0, 32'h0000_6000, 0, -1, 0);
        // R2 R7: dynamic list whose register low byte is zero, static byte 50 ignored
        run_case("empty_dynamic", "R2", 16'h0850, 1'b1, 32'h0000_7000, 0, -1, 0);
        // R8: fault on register 1 word 1 in full ascending list
        run_case("fault_asc", "R8", 16'h20FF, 1'b0, 32'h0000_8000, 0, 4, 0);
        // R8: fault on first register in pre-decrement
        run_case("fault_predec", "R8", 16'h00FF, 1'b1, 32'h0000_9000, 1, 2, 0);
        // R9: start pulsed during a long pre-decrement run with waits
        run_case("busy_start", "R9", 16'h20FF, 1'b1, 32'h0001_0000, 2, -1, 1);
        // R7: sparse mask skips registers without spending cycles
        run_case("sparse", "R7", 16'h2090, 1'b0, 32'h0000_A000, 0, -1, 0);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule